// File: doc/BRIEF.md
# Tick-Driven Countdown Timer Channel

A single timer channel that counts down by one on every cycle in which its `tick` input is high. Software programs a load value and picks either single-shot or repeating operation. It also sets the enable bit. When the count passes zero the channel raises a level interrupt. The interrupt stays high until software clears it through a control register.

The count uses a plus-one rule. A load value of N expires on the (N+1)-th tick, so a load of zero still fires after one tick. In repeating mode the channel reloads the programmed value at every expiry and keeps going. In single-shot mode it drops its own enable bit and halts at zero. Writing the trigger register again at any time restarts the countdown from the new value.

Top module: `cd_timer`

## Requirements
- R1: After reset the enable bit, the mode bit, the load value, the count and the interrupt are all zero, and every read returns zero.
- R2: A write to address 0x0 sets the enable bit from data bit 31, the repeat-mode bit from data bit 30, and the load value and the count from data bits 28:0. Each following tick lowers the count by one, and the interrupt rises after exactly N+1 ticks for a load value N.
- R3: A load value of zero with enable set expires on the first tick.
- R4: In single-shot mode (bit 30 clear), expiry clears the enable bit and leaves the count at zero. Further ticks cause no more interrupts.
- R5: In repeat mode (bit 30 set), the count is reloaded with the load value on the tick that expires. The interrupt then recurs every N+1 ticks.
- R6: Writing 0x00000000 to address 0x0 stops the channel. The count becomes zero and ticks have no effect.
- R7: A write to address 0x4 with data bit 30 set clears the interrupt. A write to 0x4 with bit 30 clear leaves the interrupt unchanged. The interrupt otherwise holds its value.
- R8: When an expiry and a clear fall in the same cycle, the interrupt ends up set.
- R9: A write to address 0x0 while counting restarts from the new value. When such a write coincides with a tick, the write wins and the tick is not counted.
- R10: The count does not change in a cycle without a tick, nor while the channel is disabled.
- R11: The count field holds 29 bits, so the longest interval is 0x1FFFFFFF+1 ticks. Data bit 29 of a trigger write is discarded.
- R12: Reads are combinational. Address 0x0 returns {enable, mode, 0, load[28:0]}. Address 0x4 returns the interrupt in bit 30. Address 0x8 returns the live count. Any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Sticky level interrupt |

## Verification
Single-shot loads from 0 to 10 are each tried with idle gaps of 0, 1 or 2 cycles between ticks. This separates counting per tick from counting per clock, and it pins the N+1 expiry point for every small value. Repeat-mode loads from 0 to 5 are run for three periods, which shows that the reload value is the load and not N+1 or N-1. Directed cases cover a stop by writing zero, a clear colliding with an expiry, a rewrite colliding with a tick, and the largest count with a stray bit 29. These cases tell apart the wrong priority choices and truncation errors.

// File: rtl/cd_timer.sv
module cd_timer #(
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8);
  localparam int EN_B  = 31;
  localparam int RPT_B = 30;
  localparam int CLR_B = 30;

  logic             en_q, rpt_q;
  logic [CNT_W-1:0] load_q, cnt_q;

  logic wr_trig, clr, expire;
  assign wr_trig = wr_en && (wr_addr == A_TRIG);
  assign clr     = wr_en && (wr_addr == A_CTRL) && wr_data[CLR_B];
  assign expire  = en_q && tick && !wr_trig && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rpt_q  <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else if (wr_trig) begin
      en_q   <= wr_data[EN_B];
      rpt_q  <= wr_data[RPT_B];
      load_q <= wr_data[CNT_W-1:0];
      cnt_q  <= wr_data[CNT_W-1:0];
    end else if (expire) begin
      if (rpt_q) cnt_q <= load_q;
      else       en_q  <= 1'b0;
    end else if (en_q && tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (clr)    irq <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TRIG: begin
        rd_data[CNT_W-1:0] = load_q;
        rd_data[EN_B]      = en_q;
        rd_data[RPT_B]     = rpt_q;
      end
      A_CTRL:  rd_data[CLR_B]     = irq;
      A_CNT:   rd_data[CNT_W-1:0] = cnt_q;
      default: rd_data = '0;
    endcase
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && !wr_trig && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && !wr_trig && cnt_q == '0) |=> irq);
  p_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !rpt_q && tick && !wr_trig && cnt_q == '0) |=> (!en_q && cnt_q == '0));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && rpt_q && tick && !wr_trig && cnt_q == '0) |=> cnt_q == $past(load_q));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_addr == A_CTRL && wr_data[CLR_B])) |=> irq);
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[CLR_B] && !(en_q && tick && !wr_trig && cnt_q == '0)) |=> !irq);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_trig && (!tick || !en_q)) |=> $stable(cnt_q));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trig |=> cnt_q == $past(wr_data[CNT_W-1:0]));
endmodule

// File: tb/cd_timer_test.sv
module cd_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] RPT = 32'h4000_0000;
  localparam logic [31:0] CLR = 32'h4000_0000;

  cd_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit we, logic [3:0] a, logic [31:0] d, bit tk);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk_cnt(string req, logic [31:0] exp);
    logic [31:0] v;
    rd(4'h8, v);
    check(req, v, exp);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1
    check("R1 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R1 read", v, 0);
    end
    rst_n = 1'b1;

    // R2 R3 R4 R10: single-shot sweep with tick gaps
    for (int n = 0; n <= 10; n++) begin
      int gap = n % 3;
      step(1, 4'h0, EN | n, 0);
      chk_cnt("R2 load", n);
      for (int k = 1; k <= n + 1; k++) begin
        step(0, 0, 0, 1);
        if (k <= n) begin
          check(n == 0 ? "R3 early" : "R2 early", {31'b0, irq}, 0);
          chk_cnt("R2 count", n - k);
        end else begin
          check(n == 0 ? "R3 fire" : "R2 fire", {31'b0, irq}, 1);
          chk_cnt("R4 count", 0);
        end
        for (int g = 0; g < gap; g++) begin
          step(0, 0, 0, 0);
          chk_cnt("R10 hold", k <= n ? n - k : 0);
        end
      end
      rd(4'h0, v);
      check("R4 enable cleared", v, n);
      step(1, 4'h4, CLR, 0);
      check("R7 clear", {31'b0, irq}, 0);
      for (int k = 0; k < n + 2; k++) step(0, 0, 0, 1);
      check("R4 no refire", {31'b0, irq}, 0);
      chk_cnt("R4 stays zero", 0);
    end

    // R5: repeat-mode sweep, three periods each
    for (int n = 0; n <= 5; n++) begin
      step(1, 4'h0, EN | RPT | n, 0);
      for (int p = 0; p < 3; p++) begin
        for (int k = 1; k <= n + 1; k++) begin
          step(0, 0, 0, 1);
          if (k <= n) begin
            check("R5 early", {31'b0, irq}, 0);
            chk_cnt("R5 count", n - k);
          end else begin
            check("R5 fire", {31'b0, irq}, 1);
            chk_cnt("R5 reload", n);
          end
        end
        rd(4'h4, v);
        check("R12 ctrl read", v, CLR);
        step(1, 4'h4, CLR, 0);
      end
      rd(4'h0, v);
      check("R5 still enabled", v, EN | RPT | n);
    end

    // R6: stop by writing zero
    step(1, 4'h0, EN | 5, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk_cnt("R6 pre", 3);
    step(1, 4'h0, 0, 0);
    chk_cnt("R6 zeroed", 0);
    for (int k = 0; k < 10; k++) step(0, 0, 0, 1);
    check("R6 no irq", {31'b0, irq}, 0);
    chk_cnt("R6 frozen", 0);

    // R7: bit 30 clear on ctrl write does nothing
    step(1, 4'h0, EN, 0);
    step(0, 0, 0, 1);
    check("R7 set", {31'b0, irq}, 1);
    step(1, 4'h4, 32'hBFFF_FFFF, 0);
    check("R7 other bits ignored", {31'b0, irq}, 1);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1);
    check("R7 sticky", {31'b0, irq}, 1);
    step(1, 4'h4, CLR, 0);
    check("R7 cleared", {31'b0, irq}, 0);

    // R8: clear collides with expiry
    step(1, 4'h0, EN, 0);
    step(1, 4'h4, CLR, 1);
    check("R8 expiry wins", {31'b0, irq}, 1);
    step(1, 4'h4, CLR, 0);

    // R9: restart while running, and write beats tick
    step(1, 4'h0, EN | 8, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
    chk_cnt("R9 mid", 5);
    step(1, 4'h0, EN | 2, 1);
    chk_cnt("R9 write beats tick", 2);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    check("R9 not yet", {31'b0, irq}, 0);
    step(0, 0, 0, 1);
    check("R9 fire", {31'b0, irq}, 1);
    step(1, 4'h4, CLR, 0);

    // R11: widest count, bit 29 dropped
    step(1, 4'h0, 32'hBFFF_FFFF, 0);
    rd(4'h0, v);
    check("R11 trig read", v, 32'h9FFF_FFFF);
    chk_cnt("R11 max count", 32'h1FFF_FFFF);
    step(0, 0, 0, 1);
    chk_cnt("R11 decrement", 32'h1FFF_FFFE);
    check("R11 no irq", {31'b0, irq}, 0);

    // R12: unmapped address and R10 disabled channel
    rd(4'hC, v);
    check("R12 unmapped", v, 0);
    step(1, 4'h0, 7, 0);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 1);
    chk_cnt("R10 disabled hold", 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule